// File: doc/BRIEF.md
# Scaled Counter PWM Timer

This block is a memory-mapped timer with four compare channels. A 31-bit counter advances by one on every clock while either of two run enables is set. A 4-bit scale field picks a 16-bit window of that counter, starting at bit `scale`. The window value is compared against four 16-bit compare registers. When the window value is at or above a channel's compare value, that channel's pending flag is set on the next clock. The flag drives the channel's interrupt line.

Channel 0 can be set to return the counter to zero when it matches. This gives a programmable period. A one-shot enable turns itself off when that zero return happens, or when the counter carries out of its 31-bit range. Software can load the counter directly, or through the scaled window.

Access uses a single-cycle port with valid, write, address and write data. Read data is registered. Configuration bits for centred, ganged, deglitched and sticky operation are stored and read back, but they have no effect.

Top module: `pwm_scaled_timer`

## Requirements
- R1: While `rst` is high, `irq` is all zero. The first reads after reset of the configuration register (offset 0x00), the counter (0x08) and compare register 0 (0x20) return zero.
- R2: The counter register at offset 0x08 is 31 bits wide. Bit 31 always reads as zero, so writing 0xFFFFFFFF reads back as 0x7FFFFFFF. The counter wraps modulo 2^31.
- R3: Compare register i sits at offset 0x20 + 4*i, for i from 0 to 3. Only the low 16 bits of the written data are kept, and bits 31:16 read as zero.
- R4: The counter rises by one on every clock while configuration bit 12 (run always) or bit 13 (one-shot) is set. It holds its value while both bits are clear.
- R5: The register at offset 0x10 reads (count >> scale) & 0xFFFF, where scale is configuration bits 3:0.
- R6: When the scaled value is greater than or equal to compare register i, pending bit i (configuration bit 28+i) and `irq[i]` are set on the next clock. They stay set until software clears them.
- R7: When configuration bit 9 (zero on channel 0) is set and channel 0 matches, the counter becomes zero on the same edge that sets pending bit 0. The one-shot bit is cleared on that edge.
- R8: When the running counter steps from 0x7FFFFFFF to 0, the one-shot bit (bit 13) is cleared. The counter then holds at zero unless bit 12 is set.
- R9: Writing offset 0x10 loads the counter with (data & 0xFFFF) << scale, truncated to 31 bits.
- R10: A configuration write loads the pending bits from data bits 31:28. A bit written as zero deasserts that channel's `irq`, unless the channel matches on the same edge. A bit written as one asserts it.
- R11: Configuration bits 8, 10, 19:16 and 27:24 are stored and read back without effect. Bits 7:4, 11, 15:14 and 23:20 read as zero.
- R12: A read returns its data on `bus_rdata` one clock after the read is accepted. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt, equal to the pending bits |

## Verification
The compare path is driven by a vector table that pairs counter values with scale settings of 0, 4, 8, 12 and 15. Some entries put the window value exactly on the compare value, some one below it. Others set bits above the window, to show that they do not leak into the comparison. This separates a wrong shift, a wrong mask and a strict-versus-inclusive compare.

Directed runs then read the counter on consecutive cycles in three cases:
- a free run;
- a period set by channel 0;
- a one-shot run that crosses the 31-bit carry.

Each case yields an exact sequence of values. These sequences expose off-by-one errors in the increment, the zero return and the carry stop. Further directed checks cover the loads through the scaled window, the set and clear of the pending bits, and the inert configuration bits.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    localparam int NCH       = 4;
    localparam int CNT_W     = 31;
    localparam int CMP_W     = 16;
    localparam int SCALE_W   = 4;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int CMP_STEP  = 4;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SCALED = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CMP0   = 8'h20;

    // configuration word bit positions
    localparam int B_STICKY  = 8;
    localparam int B_ZERO    = 9;
    localparam int B_DEGL    = 10;
    localparam int B_ALWAYS  = 12;
    localparam int B_ONESHOT = 13;
    localparam int B_CENTER  = 16;
    localparam int B_GANG    = 24;
    localparam int B_PEND    = 28;

    typedef struct packed {
        logic [NCH-1:0]     pend;
        logic [NCH-1:0]     gang;
        logic [NCH-1:0]     center;
        logic               oneshot;
        logic               run_always;
        logic               deglitch;
        logic               zero_on_ch0;
        logic               sticky;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SCALE_W-1:0]          = c.scale;
        w[B_STICKY]             = c.sticky;
        w[B_ZERO]               = c.zero_on_ch0;
        w[B_DEGL]               = c.deglitch;
        w[B_ALWAYS]             = c.run_always;
        w[B_ONESHOT]            = c.oneshot;
        w[B_CENTER +: NCH]      = c.center;
        w[B_GANG +: NCH]        = c.gang;
        w[B_PEND +: NCH]        = c.pend;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        cfg_t c;
        c.scale       = w[SCALE_W-1:0];
        c.sticky      = w[B_STICKY];
        c.zero_on_ch0 = w[B_ZERO];
        c.deglitch    = w[B_DEGL];
        c.run_always  = w[B_ALWAYS];
        c.oneshot     = w[B_ONESHOT];
        c.center      = w[B_CENTER +: NCH];
        c.gang        = w[B_GANG +: NCH];
        c.pend        = w[B_PEND +: NCH];
        return c;
    endfunction

    function automatic logic [CMP_W-1:0] window_of(logic [CNT_W-1:0] cnt,
                                                  logic [SCALE_W-1:0] sc);
        logic [CNT_W-1:0] sh;
        sh = cnt >> sc;
        return sh[CMP_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] window_to_count(logic [CMP_W-1:0] v,
                                                        logic [SCALE_W-1:0] sc);
        logic [CNT_W-1:0] wide;
        wide = {{(CNT_W-CMP_W){1'b0}}, v};
        return wide << sc;
    endfunction
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
    import pwm_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stop_oneshot,
    output cfg_t              cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q      <= word_to_cfg(wdata);
            cfg_q.pend <= '0;
        end else if (stop_oneshot) begin
            cfg_q.oneshot <= 1'b0;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import pwm_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             zero_evt,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);
    logic [CNT_W-1:0] cnt_q;

    // carry out of the top only counts when the increment really happens
    assign carry = run && (&cnt_q) && !load && !zero_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (zero_evt) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import pwm_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             cfg_wr,
    input  logic             pend_wdata,
    input  logic [CMP_W-1:0] window,
    output logic [CMP_W-1:0] cmp_val,
    output logic             match,
    output logic             pend
);
    logic [CMP_W-1:0] cmp_q;
    logic             pend_q;

    assign match = (window >= cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_wdata;
            pend_q <= (cfg_wr ? pend_wdata : pend_q) | match;
        end
    end

    assign cmp_val = cmp_q;
    assign pend    = pend_q;
endmodule

// File: rtl/pwm_scaled_timer.sv
module pwm_scaled_timer
    import pwm_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    logic wr_cfg, wr_cnt, wr_win, rd_en;
    logic [NCH-1:0] wr_cmp;

    assign rd_en  = bus_valid && !bus_write;
    assign wr_cfg = bus_valid && bus_write && (bus_addr == OFF_CFG);
    assign wr_cnt = bus_valid && bus_write && (bus_addr == OFF_CNT);
    assign wr_win = bus_valid && bus_write && (bus_addr == OFF_SCALED);

    cfg_t cfg;
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] window;
    logic [NCH-1:0] match, pend;
    logic [NCH-1:0][CMP_W-1:0] cmp_val;
    logic run, carry, zero_evt, load;
    logic [CNT_W-1:0] load_val;

    assign run      = cfg.run_always || cfg.oneshot;
    assign window   = window_of(cnt, cfg.scale);
    assign zero_evt = cfg.zero_on_ch0 && match[0];
    assign load     = wr_cnt || wr_win;
    assign load_val = wr_cnt ? bus_wdata[CNT_W-1:0]
                             : window_to_count(bus_wdata[CMP_W-1:0], cfg.scale);

    tmr_cfg_reg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_cfg),
        .wdata        (bus_wdata),
        .stop_oneshot (zero_evt || carry),
        .cfg          (cfg)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .load     (load),
        .load_val (load_val),
        .zero_evt (zero_evt),
        .cnt      (cnt),
        .carry    (carry)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign wr_cmp[g] = bus_valid && bus_write &&
                           (bus_addr == OFF_CMP0 + ADDR_W'(CMP_STEP * g));
        tmr_cmp_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .cmp_wr     (wr_cmp[g]),
            .cmp_wdata  (bus_wdata[CMP_W-1:0]),
            .cfg_wr     (wr_cfg),
            .pend_wdata (bus_wdata[B_PEND + g]),
            .window     (window),
            .cmp_val    (cmp_val[g]),
            .match      (match[g]),
            .pend       (pend[g])
        );
    end

    assign irq = pend;

    // read mux; unmapped offsets give zero
    logic [DATA_W-1:0] rd_mux, rdata_q;
    cfg_t cfg_view;

    always_comb begin
        cfg_view      = cfg;
        cfg_view.pend = pend;
        rd_mux        = '0;
        if (bus_addr == OFF_CFG)    rd_mux = cfg_to_word(cfg_view);
        if (bus_addr == OFF_CNT)    rd_mux = {{(DATA_W-CNT_W){1'b0}}, cnt};
        if (bus_addr == OFF_SCALED) rd_mux = {{(DATA_W-CMP_W){1'b0}}, window};
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == OFF_CMP0 + ADDR_W'(CMP_STEP * i))
                rd_mux = {{(DATA_W-CMP_W){1'b0}}, cmp_val[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwm_scaled_timer_chk.sv
module pwm_scaled_timer_chk
    import pwm_tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             load,
    input logic             zero_evt,
    input logic             cfg_wr,
    input logic             oneshot,
    input logic [NCH-1:0]   match,
    input logic [NCH-1:0]   irq
);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !load && !zero_evt) |=> $stable(cnt));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !zero_evt && !(&cnt)) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    p_pend_after_match_r6: assert property (@(posedge clk) disable iff (rst)
        (|match) |=> ((irq & $past(match)) == $past(match)));

    p_zero_return_r7: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && !load && !cfg_wr) |=> (cnt == '0 && !oneshot));

    p_carry_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (run && (&cnt) && !load && !zero_evt && !cfg_wr) |=> (cnt == '0 && !oneshot));
endmodule

bind pwm_scaled_timer pwm_scaled_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .run      (run),
    .load     (load),
    .zero_evt (zero_evt),
    .cfg_wr   (wr_cfg),
    .oneshot  (cfg.oneshot),
    .match    (match),
    .irq      (irq)
);

// File: tb/pwm_scaled_timer_tb.sv
`timescale 1ns/1ps
module pwm_scaled_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_scaled_timer u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h08, A_WIN = 8'h10,
                           A_C0 = 8'h20, A_C1 = 8'h24, A_C2 = 8'h28;

    typedef struct packed {
        logic [3:0]  scale;
        logic [31:0] count;
        logic [15:0] cmp;
        logic [15:0] exp_win;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  32'h0000_1234, 16'h1234, 16'h1234, 1'b1},
        '{4'd0,  32'h0000_1234, 16'h1235, 16'h1234, 1'b0},
        '{4'd4,  32'h0001_2345, 16'h1234, 16'h1234, 1'b1},
        '{4'd8,  32'h00AB_CDEF, 16'hABCE, 16'hABCD, 1'b0},
        '{4'd15, 32'h7FFF_8000, 16'hFFFF, 16'hFFFF, 1'b1},
        '{4'd0,  32'h7FFF_0005, 16'h0006, 16'h0005, 1'b0},
        '{4'd12, 32'h1234_5678, 16'h2345, 16'h2345, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    // each access starts at a falling edge and ends at the next one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq in reset", {28'd0, irq}, 32'd0);
        rst = 1'b0;
        rd(A_CFG, d); check("R1 cfg after reset", d, 32'd0);
        rd(A_CNT, d); check("R1 count after reset", d, 32'd0);
        rd(A_C0, d);  check("R1 cmp0 after reset", d, 32'd0);

        // vector table: window slice and compare
        for (int i = 0; i < NV; i++) begin
            wr(A_CFG, {28'd0, VEC[i].scale});
            wr(A_CNT, VEC[i].count);
            wr(A_C0, {16'd0, VEC[i].cmp});
            wr(A_CFG, {28'd0, VEC[i].scale});
            rd(A_WIN, d);
            check("R5 window read", d, {16'd0, VEC[i].exp_win});
            check("R6 irq0 vs compare", {31'd0, irq[0]}, {31'd0, VEC[i].exp_irq});
        end

        // R2 counter width
        wr(A_CFG, 32'd0);
        wr(A_CNT, 32'hFFFF_FFFF);
        rd(A_CNT, d); check("R2 bit31 reads zero", d, 32'h7FFF_FFFF);

        // R3 compare masking
        wr(A_C1, 32'hABCD_1234);
        rd(A_C1, d); check("R3 cmp1 upper bits dropped", d, 32'h0000_1234);

        // R12 unmapped
        wr(A_CNT, 32'd77);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R12 unmapped read", d, 32'd0);
        rd(8'h30, d); check("R12 unmapped read 0x30", d, 32'd0);
        rd(A_CNT, d); check("R12 unmapped write ignored", d, 32'd77);

        // R11 stored inert bits
        wr(A_CFG, 32'h0FFF_CFFF);
        rd(A_CFG, d); check("R11 cfg readback", d & 32'h0FFF_FFFF, 32'h0F0F_070F);
        wr(A_CFG, 32'd0);

        // R4 free run
        wr(A_CNT, 32'd100);
        wr(A_CFG, 32'h0000_1000);
        rd(A_CNT, d); check("R4 count at start", d, 32'd100);
        repeat (10) @(negedge clk);
        rd(A_CNT, d); check("R4 count after 11 clocks", d, 32'd111);
        wr(A_CFG, 32'd0);
        rd(A_CNT, d); check("R4 count at stop", d, 32'd113);
        repeat (5) @(negedge clk);
        rd(A_CNT, d2); check("R4 count held", d2, 32'd113);

        // R7 period via channel 0
        wr(A_C0, 32'd3);
        wr(A_CNT, 32'd0);
        wr(A_CFG, 32'h0000_1200);
        rd(A_CNT, d); check("R7 seq 0", d, 32'd0);
        check("R10 irq0 cleared by cfg write", {31'd0, irq[0]}, 32'd0);
        rd(A_CNT, d); check("R7 seq 1", d, 32'd1);
        rd(A_CNT, d); check("R7 seq 2", d, 32'd2);
        rd(A_CNT, d); check("R7 seq 3", d, 32'd3);
        check("R6 irq0 after match", {31'd0, irq[0]}, 32'd1);
        rd(A_CNT, d); check("R7 seq back to 0", d, 32'd0);

        // R7 one-shot stops at zero return
        wr(A_CFG, 32'd0);
        wr(A_C0, 32'd2);
        wr(A_CNT, 32'd0);
        wr(A_CFG, 32'h0000_2200);
        repeat (8) @(negedge clk);
        rd(A_CFG, d); check("R7 one-shot bit cleared", {31'd0, d[13]}, 32'd0);
        rd(A_CNT, d); check("R7 count parked at zero", d, 32'd0);

        // R8 carry stop
        wr(A_CFG, 32'd0);
        wr(A_C0, 32'h0000_FFFF);
        wr(A_CNT, 32'h7FFF_FFFD);
        wr(A_CFG, 32'h0000_2000);
        rd(A_CNT, d); check("R8 seq FD", d, 32'h7FFF_FFFD);
        rd(A_CNT, d); check("R8 seq FE", d, 32'h7FFF_FFFE);
        rd(A_CNT, d); check("R8 seq FF", d, 32'h7FFF_FFFF);
        rd(A_CNT, d); check("R8 wrapped to 0", d, 32'd0);
        rd(A_CNT, d); check("R8 stopped at 0", d, 32'd0);
        rd(A_CFG, d); check("R8 one-shot bit cleared", {31'd0, d[13]}, 32'd0);

        // R9 load through window
        wr(A_CFG, 32'd4);
        wr(A_WIN, 32'hABCD_1234);
        rd(A_CNT, d); check("R9 window load scale 4", d, 32'h0001_2340);
        rd(A_WIN, d); check("R9 window readback", d, 32'h0000_1234);
        wr(A_CFG, 32'd15);
        wr(A_WIN, 32'h0001_FFFF);
        rd(A_CNT, d); check("R9 window load scale 15", d, 32'h7FFF_8000);

        // R10 pending bits written by software
        wr(A_CFG, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_C1, 32'd0);
        wr(A_C2, 32'h0000_FFFF);
        wr(A_CFG, 32'h4000_0000);
        rd(A_CFG, d);
        check("R10 clear loses to live match ch1", {31'd0, d[29]}, 32'd1);
        check("R10 software set ch2", {31'd0, irq[2]}, 32'd1);
        wr(A_CFG, 32'd0);
        check("R10 software clear ch2", {31'd0, irq[2]}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule